// File: doc/BRIEF.md
# Flash Read-Path Output Selector

This block is the read side of a simple NOR flash model with an asynchronous-style pin interface. The pins are sampled on a model clock. It keeps track of the current read source: the storage array, the status byte or the identification bytes. On every clock it works out what the 16-bit data bus shows and which of its bits are driven. The inputs it uses are the chip-enable, output-enable and write-enable levels (all active low) and the byte-width select. It also uses the address and the extra low address bit used in byte mode.

The mode changes in three ways. A command decoder can send a mode strobe carrying a 2-bit code. The start of a program or erase operation, seen as a rising busy level, moves the block to status mode. An identification override, which stands for a high voltage on the address pin, shows the ID bytes for as long as it is held. The stored mode is not changed by the override, so the previous source comes back when it is released.

The status byte is captured when a read becomes enabled, that is, when the later of the two enables goes low. It then stays frozen until one enable is toggled. Outputs are registered, so each bus value reflects the pins sampled at the previous rising clock edge.

Top module: `flash_read_mux`

## Requirements
- R1: After reset the outputs are undriven (`dq_oe` = 0, `dq_out` = 0) and the read source is the array.
- R2: A read is enabled only when `we_n`=1, `ce_n`=0 and `oe_n`=0. In every other case `dq_oe` and `dq_out` are all zero one cycle later.
- R3: Array source with `byte_n`=1 drives `array_word` on all 16 bits. With `byte_n`=0, bits 7:0 carry `array_word[15:8]` when `byte_sel`=1 and `array_word[7:0]` when `byte_sel`=0, and bits 15:8 are undriven.
- R4: Array output follows a change of `array_word` or `byte_sel` on the next cycle, with no toggle of the enables.
- R5: Status source ignores the address. It drives the captured status on bits 7:0. Bits 15:8 are driven as zero when `byte_n`=1 and are undriven when `byte_n`=0.
- R6: The status byte is captured in the cycle a read becomes enabled. While the read stays enabled the output does not change. It is refreshed only by disabling and re-enabling the read.
- R7: A rising edge on `busy` sets the stored mode to status (code 01). While `busy` is high, reads return status whatever the stored mode is. After `busy` falls, status stays in force until a mode strobe arrives.
- R8: ID source decodes only `addr[0]`: 0 gives `MFR_ID` and 1 gives `DEV_ID` on bits 7:0. With `byte_n`=1, bits 15:8 are `MFR_HI` (default 00h) or `DEV_HI` (default 88h). With `byte_n`=0 they are undriven.
- R9: While `id_ovr`=1, reads return ID data whatever the mode. On release, the mode that was in force before (and any strobe accepted meanwhile) is restored.
- R10: `mode_stb` with `mode_code` 00 selects array, 01 selects status and 10 selects ID. Code 11 leaves the mode unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Model clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ce_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write enable, active low |
| byte_n | input | 1 | 1 = 16-bit bus, 0 = 8-bit bus |
| addr | input | AW | Address; only bit 0 is decoded (ID source) |
| byte_sel | input | 1 | Lowest address bit in 8-bit mode |
| mode_stb | input | 1 | Mode-select strobe |
| mode_code | input | 2 | 00 array, 01 status, 10 ID, 11 ignored |
| status_in | input | 8 | Live status value |
| array_word | input | 16 | Array word at the current address |
| busy | input | 1 | Operation running or erase suspended |
| id_ovr | input | 1 | Identification override |
| dq_out | output | 16 | Data bus value (0 on undriven bits) |
| dq_oe | output | 16 | Per-bit drive enable |

## Verification
The hardest conditions to reach are those where the stored mode and the read source seen on the bus differ. This happens while `busy` or `id_ovr` masks the stored mode, and the bench must show that the mask lifts back to the right source. The stimulus sends strobes and busy edges while the override is held and then releases it. It also holds a status read enabled while `status_in` changes, and then toggles each enable in turn. A reference model tracks the capture point. Every mode, width, A0 and byte-lane combination is swept with distinct data patterns.

// File: rtl/frm_pkg.sv
package frm_pkg;
  typedef enum logic [1:0] {
    MODE_ARRAY  = 2'b00,
    MODE_STATUS = 2'b01,
    MODE_IDENT  = 2'b10
  } rd_mode_e;

  localparam logic [1:0] CODE_ILLEGAL = 2'b11;
endpackage

// File: rtl/frm_mode_ctl.sv
module frm_mode_ctl
  import frm_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       mode_stb,
  input  logic [1:0] mode_code,
  input  logic       busy,
  input  logic       id_ovr,
  output rd_mode_e   eff_mode
);
  rd_mode_e mode_q;
  logic     busy_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q <= MODE_ARRAY;
      busy_q <= 1'b0;
    end else begin
      busy_q <= busy;
      if (busy && !busy_q)
        mode_q <= MODE_STATUS;
      else if (mode_stb && mode_code != CODE_ILLEGAL)
        mode_q <= rd_mode_e'(mode_code);
    end
  end

  always_comb begin
    if (id_ovr)    eff_mode = MODE_IDENT;
    else if (busy) eff_mode = MODE_STATUS;
    else           eff_mode = mode_q;
  end
endmodule

// File: rtl/frm_status_cap.sv
module frm_status_cap #(
  parameter int SW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rd_en,
  input  logic [SW-1:0] status_in,
  output logic [SW-1:0] status_view
);
  logic [SW-1:0] held_q;
  logic          rd_q;
  logic          open_now;

  assign open_now = rd_en && !rd_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      held_q <= '0;
      rd_q   <= 1'b0;
    end else begin
      rd_q <= rd_en;
      if (open_now) held_q <= status_in;
    end
  end

  assign status_view = open_now ? status_in : held_q;
endmodule

// File: rtl/frm_lane_mux.sv
module frm_lane_mux
  import frm_pkg::*;
#(
  parameter int         DW     = 16,
  parameter logic [7:0] MFR_ID = 8'h2C,
  parameter logic [7:0] DEV_ID = 8'h9C,
  parameter logic [7:0] MFR_HI = 8'h00,
  parameter logic [7:0] DEV_HI = 8'h88
) (
  input  rd_mode_e        eff_mode,
  input  logic            rd_en,
  input  logic            byte_n,
  input  logic            a0,
  input  logic            byte_sel,
  input  logic [DW-1:0]   array_word,
  input  logic [DW/2-1:0] status_v,
  output logic [DW-1:0]   dq_d,
  output logic [DW-1:0]   oe_d
);
  localparam int HW = DW / 2;

  logic [HW-1:0] lo_val, hi_val;
  logic          hi_drive;

  always_comb begin
    lo_val   = '0;
    hi_val   = '0;
    hi_drive = byte_n;
    unique case (eff_mode)
      MODE_ARRAY: begin
        if (byte_n) begin
          lo_val = array_word[HW-1:0];
          hi_val = array_word[DW-1:HW];
        end else begin
          lo_val = byte_sel ? array_word[DW-1:HW] : array_word[HW-1:0];
        end
      end
      MODE_STATUS: lo_val = status_v;
      MODE_IDENT: begin
        lo_val = HW'(a0 ? DEV_ID : MFR_ID);
        hi_val = HW'(a0 ? DEV_HI : MFR_HI);
      end
      default: hi_drive = 1'b0;
    endcase
  end

  for (genvar g = 0; g < 2; g++) begin : g_lane
    logic drive;
    assign drive = rd_en && (g == 0 ? 1'b1 : hi_drive);
    assign oe_d[g*HW +: HW] = {HW{drive}};
    assign dq_d[g*HW +: HW] = drive ? (g == 0 ? lo_val : hi_val) : '0;
  end
endmodule

// File: rtl/flash_read_mux.sv
module flash_read_mux
  import frm_pkg::*;
#(
  parameter int         AW     = 19,
  parameter logic [7:0] MFR_ID = 8'h2C,
  parameter logic [7:0] DEV_ID = 8'h9C,
  parameter logic [7:0] MFR_HI = 8'h00,
  parameter logic [7:0] DEV_HI = 8'h88
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ce_n,
  input  logic          oe_n,
  input  logic          we_n,
  input  logic          byte_n,
  input  logic [AW-1:0] addr,
  input  logic          byte_sel,
  input  logic          mode_stb,
  input  logic [1:0]    mode_code,
  input  logic [7:0]    status_in,
  input  logic [15:0]   array_word,
  input  logic          busy,
  input  logic          id_ovr,
  output logic [15:0]   dq_out,
  output logic [15:0]   dq_oe
);
  localparam int DW = 16;
  localparam int HW = DW / 2;

  rd_mode_e      eff_mode;
  logic          rd_en;
  logic [HW-1:0] status_v;
  logic [DW-1:0] dq_d, oe_d;
  logic          unused_addr_hi;

  assign rd_en          = we_n && !ce_n && !oe_n;
  assign unused_addr_hi = ^addr[AW-1:1];

  frm_mode_ctl u_mode (
    .clk(clk), .rst_n(rst_n), .mode_stb(mode_stb), .mode_code(mode_code),
    .busy(busy), .id_ovr(id_ovr), .eff_mode(eff_mode)
  );

  frm_status_cap #(.SW(HW)) u_stat (
    .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .status_in(status_in),
    .status_view(status_v)
  );

  frm_lane_mux #(
    .DW(DW), .MFR_ID(MFR_ID), .DEV_ID(DEV_ID), .MFR_HI(MFR_HI), .DEV_HI(DEV_HI)
  ) u_lane (
    .eff_mode(eff_mode), .rd_en(rd_en), .byte_n(byte_n), .a0(addr[0]),
    .byte_sel(byte_sel), .array_word(array_word), .status_v(status_v),
    .dq_d(dq_d), .oe_d(oe_d)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dq_out <= '0;
      dq_oe  <= '0;
    end else begin
      dq_out <= dq_d;
      dq_oe  <= oe_d;
    end
  end
endmodule

// File: rtl/frm_read_chk.sv
module frm_read_chk #(
  parameter int         AW     = 19,
  parameter logic [7:0] MFR_ID = 8'h2C,
  parameter logic [7:0] DEV_ID = 8'h9C,
  parameter logic [7:0] MFR_HI = 8'h00,
  parameter logic [7:0] DEV_HI = 8'h88
) (
  input logic          clk,
  input logic          rst_n,
  input logic          ce_n,
  input logic          oe_n,
  input logic          we_n,
  input logic          byte_n,
  input logic [AW-1:0] addr,
  input logic          busy,
  input logic          id_ovr,
  input logic [15:0]   dq_out,
  input logic [15:0]   dq_oe
);
  logic rd;
  assign rd = we_n && !ce_n && !oe_n;

  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    !$past(rst_n) |-> (dq_oe == 16'h0 && dq_out == 16'h0));

  // R2
  idle_float_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(rd) |-> (dq_oe == 16'h0 && dq_out == 16'h0));

  // R3
  narrow_lanes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rd && !byte_n) |-> dq_oe == 16'h00FF);

  // R3
  wide_lanes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rd && byte_n) |-> dq_oe == 16'hFFFF);

  // R9
  ovr_ident_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rd && id_ovr && byte_n) |->
      dq_out == ($past(addr[0]) ? {DEV_HI, DEV_ID} : {MFR_HI, MFR_ID}));

  // R6
  status_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n, 2) && $past(rd) && $past(rd, 2) &&
     $past(busy && !id_ovr) && $past(busy && !id_ovr, 2)) |-> $stable(dq_out[7:0]));
endmodule

bind flash_read_mux frm_read_chk #(
  .AW(AW), .MFR_ID(MFR_ID), .DEV_ID(DEV_ID), .MFR_HI(MFR_HI), .DEV_HI(DEV_HI)
) u_chk (
  .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
  .byte_n(byte_n), .addr(addr), .busy(busy), .id_ovr(id_ovr),
  .dq_out(dq_out), .dq_oe(dq_oe)
);

// File: tb/flash_read_mux_bench.sv
module flash_read_mux_bench;
  localparam int CLK_P = 10;
  localparam int AW = 19;
  localparam logic [7:0] MFR_ID = 8'h2C, DEV_ID = 8'h9C, MFR_HI = 8'h00, DEV_HI = 8'h88;

  logic clk = 0, rst_n = 0;
  logic ce_n = 1, oe_n = 1, we_n = 1, byte_n = 1, byte_sel = 0;
  logic [AW-1:0] addr = '0;
  logic mode_stb = 0, busy = 0, id_ovr = 0;
  logic [1:0] mode_code = 0;
  logic [7:0] status_in = 0;
  logic [15:0] array_word = 0;
  logic [15:0] dq_out, dq_oe;

  int n_chk = 0, n_bad = 0;
  logic [1:0] m_mode = 0;
  logic [7:0] m_stat = 0;
  logic m_prev = 0, m_busyq = 0;
  logic [15:0] e_out, e_oe;

  always #(CLK_P/2) clk = ~clk;

  flash_read_mux #(.AW(AW), .MFR_ID(MFR_ID), .DEV_ID(DEV_ID),
                   .MFR_HI(MFR_HI), .DEV_HI(DEV_HI)) u_flash_read_mux (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
    .byte_n(byte_n), .addr(addr), .byte_sel(byte_sel), .mode_stb(mode_stb),
    .mode_code(mode_code), .status_in(status_in), .array_word(array_word),
    .busy(busy), .id_ovr(id_ovr), .dq_out(dq_out), .dq_oe(dq_oe));

  // reference: compute expected bus from requirement text
  task automatic model_edge();
    logic rd;
    logic [1:0] src;
    rd  = we_n && !ce_n && !oe_n;
    src = id_ovr ? 2'b10 : (busy ? 2'b01 : m_mode);
    if (rd && !m_prev) m_stat = status_in;
    e_out = 0; e_oe = 0;
    if (rd) begin
      e_oe = byte_n ? 16'hFFFF : 16'h00FF;
      case (src)
        2'b00: e_out = byte_n ? array_word
                              : {8'h00, byte_sel ? array_word[15:8] : array_word[7:0]};
        2'b01: e_out = {8'h00, m_stat};
        default: e_out = byte_n ? (addr[0] ? {DEV_HI, DEV_ID} : {MFR_HI, MFR_ID})
                                : {8'h00, addr[0] ? DEV_ID : MFR_ID};
      endcase
    end
    m_prev = rd;
    if (busy && !m_busyq) m_mode = 2'b01;
    else if (mode_stb && mode_code != 2'b11) m_mode = mode_code;
    m_busyq = busy;
  endtask

  task automatic step(input string req);
    @(posedge clk);
    model_edge();
    @(negedge clk);
    n_chk++;
    if (dq_out !== e_out || dq_oe !== e_oe) begin
      n_bad++;
      $display("FAIL %s: out=%h oe=%h expected out=%h oe=%h", req, dq_out, dq_oe, e_out, e_oe);
    end
  endtask

  task automatic set_rd(input logic on);
    ce_n = !on; oe_n = !on; we_n = 1;
  endtask

  task automatic strobe(input logic [1:0] code, input string req);
    set_rd(0); mode_stb = 1; mode_code = code;
    step(req);
    mode_stb = 0;
  endtask

  initial begin
    #(CLK_P * 100000);
    n_bad++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    @(negedge clk); @(negedge clk);
    n_chk++;
    if (dq_oe !== 16'h0 || dq_out !== 16'h0) begin
      n_bad++; $display("FAIL R1: out=%h oe=%h expected 0000/0000", dq_out, dq_oe);
    end
    rst_n = 1;
    // R1: first read after reset comes from the array
    array_word = 16'hA55A; set_rd(1); step("R1");
    set_rd(0); step("R2");

    // R3 R5 R8 R10: full sweep over mode, width, A0 and byte lane
    for (int m = 0; m < 3; m++) begin
      strobe(2'(m), "R10");
      for (int v = 0; v < 8; v++) begin
        byte_n = v[2]; addr = AW'(v[1]); byte_sel = v[0];
        array_word = 16'h1234 ^ (16'(m) << 12) ^ (16'(v) * 16'h0F11);
        status_in  = 8'h40 + 8'(m * 8 + v);
        set_rd(1);
        step(m == 0 ? "R3" : (m == 1 ? "R5" : "R8"));
        set_rd(0); step("R2");
      end
    end

    // R2: write enable low blocks the read; each enable alone blocks it
    byte_n = 1; strobe(2'b00, "R10");
    ce_n = 0; oe_n = 0; we_n = 0; step("R2");
    we_n = 1; ce_n = 1; step("R2");
    ce_n = 0; oe_n = 1; step("R2");

    // R4: array output follows data/byte lane with enables held
    set_rd(1); array_word = 16'hBEEF; step("R4");
    array_word = 16'h0F0F; step("R4");
    byte_n = 0; byte_sel = 1; array_word = 16'hC3A1; step("R4");
    byte_sel = 0; step("R4");
    set_rd(0); byte_n = 1; step("R2");

    // R6: status frozen while read held, refreshed by toggling either enable
    strobe(2'b01, "R10");
    status_in = 8'h11; set_rd(1); step("R6");
    status_in = 8'h22; step("R6");
    status_in = 8'h33; step("R6");
    oe_n = 1; step("R6");
    oe_n = 0; step("R6");
    status_in = 8'h44; ce_n = 1; step("R6");
    ce_n = 0; step("R6");
    set_rd(0); step("R2");

    // R7: busy rising forces status; persists after busy falls
    strobe(2'b00, "R10");
    busy = 1; status_in = 8'h80; step("R7");
    set_rd(1); step("R7");
    strobe(2'b10, "R7");
    set_rd(1); addr = 0; step("R7");
    set_rd(0); busy = 0; step("R7");
    set_rd(1); status_in = 8'h81; step("R7");
    set_rd(0); step("R2");
    busy = 1; step("R7");
    busy = 0; strobe(2'b00, "R7");
    set_rd(1); array_word = 16'h7E57; step("R7");
    set_rd(0); step("R2");

    // R9: override shows ID in every mode and restores the stored mode
    for (int m = 0; m < 3; m++) begin
      strobe(2'(m), "R10");
      id_ovr = 1;
      for (int a = 0; a < 2; a++) begin
        addr = AW'(a); byte_n = 1; set_rd(1); step("R9");
        set_rd(0); step("R2");
      end
      id_ovr = 0; status_in = 8'h90 + 8'(m); array_word = 16'h5000 + 16'(m);
      set_rd(1); step("R9");
      set_rd(0); step("R2");
    end
    // R9: strobe accepted during override takes effect on release
    strobe(2'b01, "R10");
    id_ovr = 1; strobe(2'b00, "R9");
    set_rd(1); step("R9");
    set_rd(0); id_ovr = 0; step("R2");
    set_rd(1); array_word = 16'hD00D; step("R9");
    set_rd(0); step("R2");

    // R10: illegal code ignored in each mode
    for (int m = 0; m < 3; m++) begin
      strobe(2'(m), "R10");
      strobe(2'b11, "R10");
      addr = 1; status_in = 8'hE0 + 8'(m); set_rd(1); step("R10");
      set_rd(0); step("R2");
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule